// File: doc/BRIEF.md
# Two-wire slave front end with 2K-byte storage

This block is a slave on a two-wire serial bus (I2C). It owns a 2048 x 8 register file. The block runs entirely in the system clock domain. It oversamples the bus clock and data lines through synchronizers and recognises START and STOP conditions on those sampled lines. It decodes the header byte that follows each START. It never drives the data line high: its only bus output is an enable that pulls SDA low, for use with an external open-drain pad.

A header byte carries a fixed device type, three high address bits and a direction bit. A write loads an 11-bit pointer from the header's high bits and a following word-address byte, then stores each further byte at the pointer. A read streams bytes from the current pointer for as long as the master keeps acknowledging. The pointer advances after every byte, in either direction, and wraps at the top of the array. A random read is a write header plus a word address, followed by a repeated START and a read header.

Top module: `i2cmem_slave`

## Requirements
- R1: After reset the SDA pull-low enable is off, the address pointer is 0 and every storage byte reads 0.
- R2: A header byte whose bits 7:4 differ from 1010 gets no acknowledge. No further byte is acknowledged or stored until the next START, and the pointer is left unchanged.
- R3: A header byte whose bits 7:4 equal 1010 is acknowledged by pulling SDA low during the 9th SCL clock.
- R4: In a write (header bit 0 = 0), header bits 3:1 become pointer bits 10:8 and the next byte becomes pointer bits 7:0. Every byte after that is acknowledged and stored at the pointer.
- R5: The pointer advances by one after each byte that is written or read, and wraps from 2047 to 0.
- R6: In a read (header bit 0 = 1), header bits 3:1 are ignored and data comes from the current pointer. Each byte is sent MSB first, and a 0 bit is sent by pulling SDA low.
- R7: A read continues with the next byte while the master acknowledges. After a not-acknowledge the block pulls SDA low no more until a START or STOP.
- R8: A START in any state, including partway through a byte, drops the partial byte without storing it and restarts header decoding.
- R9: A STOP in any state, including partway through a byte, releases SDA, drops the partial byte and returns the block to idle.
- R10: A write header plus a word address, then a repeated START and a read header, returns data from the address just loaded.
- R11: The pull-low enable is only switched on while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
A table of single-byte writes is paired with random reads. Its addresses include 0, 2047, alternating bit patterns and both halves of the high-bit field, and its data ranges from all-ones to sparse values. This shows whether the three header bits really reach the top of the address. A four-byte write across 2047 followed by a streamed read shows the wrap and the acknowledge-driven continuation. A read header with nonzero high bits, taken from a known pointer, shows that those bits are ignored on reads. A foreign device type, and a START or STOP cut into a half-sent byte, are each followed by reading back the bytes they could have touched, which shows that nothing was stored and the pointer did not move.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_HOLD
  } bus_state_e;

endpackage

// File: rtl/i2cmem_lines.sv
module i2cmem_lines #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges that happen while the clock stays high are framing events
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cmem_array.sv
module i2cmem_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  // R4: a byte handed over for storage is found there one cycle later
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
#(
  parameter int         ADDR_W = 11,
  parameter int         DATA_W = 8,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              sda_pull
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int CW    = $clog2(DATA_W) + 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);
  localparam logic [CW-1:0] FULL     = CW'(DATA_W);

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [HI_W-1:0] hi,
                                                  input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic id_match(input logic [DATA_W-1:0] hdr);
    return hdr[DATA_W-1 -: 4] == DEV_ID;
  endfunction

  bus_state_e        state;
  logic [CW-1:0]     bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              rw_q;
  logic              match_q;
  logic [HI_W-1:0]   hi_q;
  logic              mack_q;

  // named internal events
  logic [DATA_W-1:0] byte_in;
  logic              receiving;
  logic              last_rise;
  logic              byte_end_fall;

  assign byte_in       = {shreg[DATA_W-2:0], sda_s};
  assign receiving     = (state == ST_HDR) || (state == ST_WADR) || (state == ST_WDAT);
  assign last_rise     = receiving && scl_rise && (bit_cnt == LAST_BIT);
  assign byte_end_fall = receiving && scl_fall && (bit_cnt == FULL);
  assign wr_en         = (state == ST_WDAT) && last_rise;
  assign wr_data       = byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      rw_q     <= 1'b0;
      match_q  <= 1'b0;
      hi_q     <= '0;
      mack_q   <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_HDR;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        ST_HDR, ST_WADR, ST_WDAT: begin
          if (scl_rise && bit_cnt < FULL) begin
            shreg   <= byte_in;
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (last_rise) begin
            case (state)
              ST_HDR: begin
                rw_q    <= sda_s;
                hi_q    <= byte_in[HI_W:1];
                match_q <= id_match(byte_in);
              end
              ST_WADR: ptr <= join_addr(hi_q, byte_in);
              default: ptr <= bump(ptr);
            endcase
          end
          if (byte_end_fall) begin
            bit_cnt <= '0;
            case (state)
              ST_HDR: begin
                state    <= match_q ? ST_HDR_ACK : ST_IDLE;
                sda_pull <= match_q;
              end
              ST_WADR: begin
                state    <= ST_WADR_ACK;
                sda_pull <= 1'b1;
              end
              default: begin
                state    <= ST_WDAT_ACK;
                sda_pull <= 1'b1;
              end
            endcase
          end
        end
        ST_HDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              state    <= ST_RDAT;
              shreg    <= rd_data;
              sda_pull <= ~rd_data[DATA_W-1];
            end else begin
              state    <= ST_WADR;
              sda_pull <= 1'b0;
            end
          end
        end
        ST_WADR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            state    <= ST_WDAT;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              state    <= ST_RACK;
              sda_pull <= 1'b0;
              ptr      <= bump(ptr);
            end else begin
              shreg    <= {shreg[DATA_W-2:0], 1'b0};
              sda_pull <= ~shreg[DATA_W-2];
              bit_cnt  <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            bit_cnt <= '0;
            if (mack_q) begin
              state    <= ST_RDAT;
              shreg    <= rd_data;
              sda_pull <= ~rd_data[DATA_W-1];
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R8: a START always rearms header decoding with the line released
  assert_start_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_HDR) && (bit_cnt == '0) && !sda_pull);

  // R9: a STOP always lands in idle with the line released
  assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_pull);

  // R11: the pull-low only starts while the sampled clock is low
  assert_pull_on_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  // R5: storing at the top address wraps the pointer to zero
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == ADDR_W'(DEPTH - 1)) |=> ptr == '0);

  // R7: after a refused read byte the line stays released
  assert_silent_after_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !sda_pull);

endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave #(
  parameter int         ADDR_W      = 11,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;

  i2cmem_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2cmem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .ptr       (ptr),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sda_pull  (sda_oe)
  );

  i2cmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (ptr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

endmodule

// File: tb/i2cmem_slave_test.sv
module i2cmem_slave_test;

  localparam int Q = 10;  // quarter bus period in system clocks
  localparam int NV = 8;
  // {address[10:0], data[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {11'h000, 8'hA5}, {11'h7FF, 8'h3C}, {11'h155, 8'h96}, {11'h2AA, 8'hFF},
    {11'h400, 8'h81}, {11'h0FF, 8'h7E}, {11'h100, 8'h5A}, {11'h6C3, 8'h01}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  int   n_cmp = 0;
  int   n_bad = 0;
  logic timed_out = 1'b0;
  logic ack;
  logic [7:0] d;

  assign sda_line = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  i2cmem_slave uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (m_scl),
    .sda_in (sda_line),
    .sda_oe (sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    bus_start();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic write_hdr(input logic [10:0] a, input string req);
    logic k;
    bus_start();
    put_byte({4'hA, a[10:8], 1'b0}, k);
    chk({req, " R3 header ack"}, k, 1);
    put_byte(a[7:0], k);
    chk({req, " R4 word address ack"}, k, 1);
  endtask

  task automatic rand_read(input logic [10:0] a, input string req);
    logic k;
    write_hdr(a, req);
    bus_rstart();
    put_byte({4'hA, 3'b000, 1'b1}, k);
    chk({req, " R10 read header ack"}, k, 1);
  endtask

  task automatic cur_read(input logic [2:0] hi, output logic [7:0] v);
    logic k;
    bus_start();
    put_byte({4'hA, hi, 1'b1}, k);
    chk("R3 read header ack", k, 1);
    get_byte(v, 1'b0);
    bus_stop();
  endtask

  task automatic run_all();
    logic k;
    // reset state
    tick(5);
    chk("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 sda_oe after reset", sda_oe, 0);
    cur_read(3'b000, d);
    chk("R1 byte at pointer 0 after reset", d, 8'h00);

    // table of single writes followed by random reads
    for (int i = 0; i < NV; i++) begin
      write_hdr(VEC[i][18:8], "R4 table");
      put_byte(VEC[i][7:0], k);
      chk("R4 table data ack", k, 1);
      bus_stop();
      rand_read(VEC[i][18:8], "R10 table");
      get_byte(d, 1'b0);
      bus_stop();
      chk("R10 table readback", d, {24'h0, VEC[i][7:0]});
    end

    // ack is raised while SCL is still low
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(i == 7 || i == 5 || i == 3 || i == 2 || i == 1);
    chk("R11 pull-low set before SCL rises", {m_scl, sda_oe}, 2'b01);
    get_bit(k);
    chk("R3 ack bit low", k, 0);
    put_byte(8'hFE, k);
    chk("R4 word address ack", k, 1);
    // header 0xAE selects A10..A8 = 111, word FE -> 7FE; four bytes across the wrap
    put_byte(8'h11, k); chk("R4 seq data ack", k, 1);
    put_byte(8'h22, k); chk("R4 seq data ack", k, 1);
    put_byte(8'h33, k); chk("R5 seq data ack after wrap", k, 1);
    put_byte(8'h44, k); chk("R5 seq data ack after wrap", k, 1);
    bus_stop();

    // streamed read across the wrap
    rand_read(11'h7FE, "R7 stream");
    get_byte(d, 1'b1); chk("R7 stream byte 0 (7FE)", d, 8'h11);
    get_byte(d, 1'b1); chk("R7 stream byte 1 (7FF)", d, 8'h22);
    get_byte(d, 1'b1); chk("R5 stream byte 2 wrapped (000)", d, 8'h33);
    get_byte(d, 1'b0); chk("R5 stream byte 3 (001)", d, 8'h44);
    // after the NACK the line must stay released
    get_byte(d, 1'b1);
    chk("R7 no drive after NACK", d, 8'hFF);
    bus_stop();

    // read header high bits are ignored
    write_hdr(11'h0FE, "R6 setup");
    put_byte(8'hC7, k); chk("R4 data ack", k, 1);
    bus_stop();
    cur_read(3'b101, d);
    chk("R6 read uses pointer 0FF, header bits ignored", d, 8'h7E);

    // foreign device type (pointer now 100)
    bus_start();
    put_byte(8'hB0, k); chk("R2 foreign header not acked", k, 0);
    put_byte(8'h00, k); chk("R2 following byte not acked", k, 0);
    put_byte(8'hEE, k); chk("R2 following byte not acked", k, 0);
    bus_stop();
    cur_read(3'b000, d);
    chk("R2 pointer and data untouched", d, 8'h5A);

    // repeated START in the middle of a data byte
    write_hdr(11'h155, "R8");
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    bus_rstart();
    put_byte(8'hA1, k); chk("R8 header after repeated START acked", k, 1);
    get_byte(d, 1'b0);
    bus_stop();
    chk("R8 partial byte not stored", d, 8'h96);

    // STOP in the middle of a data byte
    write_hdr(11'h2AA, "R9");
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    bus_stop();
    tick(Q);
    chk("R9 line released after STOP", sda_oe, 0);
    rand_read(11'h2AA, "R9 check");
    get_byte(d, 1'b0);
    bus_stop();
    chk("R9 partial byte not stored", d, 8'hFF);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (180000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule